// File: doc/BRIEF.md
# Scanline Sync CPU Stall Controller

This block decides, cycle by cycle, whether the processor may use the bus. It has two ways to stop the processor. The first is a clock-stop request (`halt_o`). It is raised in any cycle that the video fetch engine or memory refresh has claimed. The second is a ready line (`rdy_o`). It implements the wait-for-horizontal-blank register: a processor write to that address holds the processor until the line counter reaches the blank cycle.

The ready line follows the convention of an NMOS-style processor. It only holds back read cycles, so a write the processor has already started still completes on the next cycle that is not stopped. After a sync write, one grace cycle passes before the wait begins. The processor may spend that cycle on a bus access unless a DMA or refresh slot takes it.

A read-modify-write to the sync address issues two writes. The second write lands in the grace cycle, or after it if the grace cycle was stolen. Because the wait is already pending, that second write is ignored. The instruction fetch that follows then stalls, so the grace cycle is effectively cancelled.

Top module: `scanline_sync_stall`

## Requirements
- R1: `halt_o` is high in exactly those cycles in which at least one bit of `dma_req_i` is set; bit 0 is the refresh slot. The relation is combinational in the same cycle and holds during reset.
- R2: A sync write is accepted in a cycle with `cpu_strobe_i`=1, `cpu_we_i`=1, `cpu_addr_i`=`SYNC_ADDR`, `halt_o`=0 and no wait pending. In the following (grace) cycle `rdy_o` stays high, so a free grace cycle lets one read through.
- R3: From the second cycle after an accepted sync write, `rdy_o` is low in every cycle until release.
- R4: A sync write presented while `halt_o` is high is not accepted. It takes effect in the first later cycle with `halt_o` low.
- R5: `rdy_o` low does not stop writes. A read-modify-write, whose second write lands in the grace cycle or (if that cycle is taken by DMA) in the wait, still releases the following read at the blank cycle.
- R6: A sync write while a wait is pending, in the grace cycle or during the wait, neither restarts the grace cycle nor moves the release.
- R7: `rdy_o` is high in the cycle with `line_cycle_i` = `HBLANK_CYCLE` (default 105), and the pending wait clears there. `halt_o` still stops the processor in that cycle if DMA claims it.
- R8: After a release, a new sync write starts a fresh wait, which may run across the line wrap (cycle `LINE_CYCLES`-1 = 113 is followed by 0) to the next blank cycle.
- R9: Reads of the sync address, and writes to any other address, never lower `rdy_o`.
- R10: Out of reset no wait is pending and `rdy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Machine-cycle clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_cycle_i | input | 7 | Cycle index within the scan line, 0 to 113 |
| dma_req_i | input | 4 | Per-cycle DMA claims, bit 0 is refresh |
| cpu_addr_i | input | 16 | Processor bus address of the current cycle |
| cpu_strobe_i | input | 1 | Processor bus cycle valid |
| cpu_we_i | input | 1 | Processor cycle is a write |
| halt_o | output | 1 | Stop processor clock this cycle |
| rdy_o | output | 1 | Ready; low holds processor read cycles |

## Verification
Each fault in the pending state shows up at the ports within two cycles of the sync write, or at the next blank cycle. Suppose a second write restarts the wait. Then `rdy_o` rises again one cycle later, and the stalled fetch completes tens of cycles before the blank cycle. A missing grace cycle moves the first fetch of the single-write case from the cycle after the write to the blank cycle. A release at the wrong cycle, or a lost release, shows as the first resumed read landing at a line cycle other than 105. The bench therefore models the processor's read and write progress. It compares the line cycle at which the first two reads after the write complete.

// File: rtl/sync_stall_pkg.sv
package sync_stall_pkg;
  localparam int unsigned DEF_LINE_CYCLES = 114;
  localparam int unsigned DEF_HBLANK      = 105;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRACE = 2'd1,
    ST_WAIT  = 2'd2
  } stall_state_e;
endpackage

// File: rtl/sync_addr_match.sv
module sync_addr_match #(
  parameter int unsigned        ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  SYNC_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_i,
  input  logic              we_i,
  output logic              hit_o
);
  assign hit_o = strobe_i & we_i & (addr_i == SYNC_ADDR);
endmodule

// File: rtl/dma_halt_gen.sv
module dma_halt_gen #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               halt_o
);
  logic [NUM_SRC:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_or
    assign chain[g+1] = chain[g] | req_i[g];
  end
  assign halt_o = chain[NUM_SRC];
endmodule

// File: rtl/sync_wait_fsm.sv
module sync_wait_fsm
  import sync_stall_pkg::*;
#(
  parameter int unsigned LC_W = 7,
  parameter int unsigned HB   = DEF_HBLANK
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [LC_W-1:0] line_cycle_i,
  output logic            pending_o,
  output logic            rdy_o
);
  localparam logic [LC_W-1:0] HB_LC = LC_W'(HB);

  stall_state_e state_q, state_d;
  logic         at_blank;

  assign at_blank = (line_cycle_i == HB_LC);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_GRACE;
      ST_GRACE: state_d = ST_WAIT;  // grace is spent or lost, never extended
      ST_WAIT:  if (at_blank) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign pending_o = (state_q != ST_IDLE);
  assign rdy_o     = (state_q != ST_WAIT) | at_blank;
endmodule

// File: rtl/scanline_sync_stall.sv
module scanline_sync_stall
  import sync_stall_pkg::*;
#(
  parameter int unsigned       LINE_CYCLES  = DEF_LINE_CYCLES,
  parameter int unsigned       HBLANK_CYCLE = DEF_HBLANK,
  parameter int unsigned       NUM_DMA      = 4,
  parameter int unsigned       ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] SYNC_ADDR    = 16'h0C4A,
  localparam int unsigned      LC_W         = $clog2(LINE_CYCLES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LC_W-1:0]    line_cycle_i,
  input  logic [NUM_DMA-1:0] dma_req_i,
  input  logic [ADDR_W-1:0]  cpu_addr_i,
  input  logic               cpu_strobe_i,
  input  logic               cpu_we_i,
  output logic               halt_o,
  output logic               rdy_o
);
  logic sync_hit, halt_w, pending_w, accept_w;

  sync_addr_match #(.ADDR_W(ADDR_W), .SYNC_ADDR(SYNC_ADDR)) i_match (
    .addr_i   (cpu_addr_i),
    .strobe_i (cpu_strobe_i),
    .we_i     (cpu_we_i),
    .hit_o    (sync_hit)
  );

  dma_halt_gen #(.NUM_SRC(NUM_DMA)) i_halt (
    .req_i  (dma_req_i),
    .halt_o (halt_w)
  );

  // a write completes only when the clock is not stopped; repeats while pending are dropped
  assign accept_w = sync_hit & ~halt_w & ~pending_w;

  sync_wait_fsm #(.LC_W(LC_W), .HB(HBLANK_CYCLE)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (accept_w),
    .line_cycle_i (line_cycle_i),
    .pending_o    (pending_w),
    .rdy_o        (rdy_o)
  );

  assign halt_o = halt_w;
endmodule

// File: rtl/sync_stall_chk.sv
module sync_stall_chk #(
  parameter int unsigned LC_W    = 7,
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned HB      = 105
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [LC_W-1:0]    line_cycle_i,
  input logic [NUM_SRC-1:0] dma_req_i,
  input logic               halt_o,
  input logic               rdy_o,
  input logic               accept_w,
  input logic               pending_w,
  input logic               sync_hit
);
  localparam logic [LC_W-1:0] HB_LC = LC_W'(HB);

  always_comb begin
    assert_dma_halts_R1: assert ((dma_req_i != '0) == halt_o);
  end

  assert_grace_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_w |=> rdy_o);

  assert_wait_after_grace_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_w |=> ##1 (!rdy_o || line_cycle_i == HB_LC));

  assert_no_accept_halted_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_w && halt_o) |=> !pending_w);

  assert_stall_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |=> (!rdy_o || line_cycle_i == HB_LC));

  assert_repeat_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_w && sync_hit) |-> !accept_w);

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_cycle_i == HB_LC) |-> rdy_o);

  assert_stall_needs_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |-> pending_w);
endmodule

bind scanline_sync_stall sync_stall_chk #(
  .LC_W(LC_W), .NUM_SRC(NUM_DMA), .HB(HBLANK_CYCLE)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_cycle_i (line_cycle_i),
  .dma_req_i    (dma_req_i),
  .halt_o       (halt_o),
  .rdy_o        (rdy_o),
  .accept_w     (accept_w),
  .pending_w    (pending_w),
  .sync_hit     (sync_hit)
);

// File: tb/test_scanline_sync_stall.sv
module test_scanline_sync_stall;
  localparam int          LINE  = 114;
  localparam int          HB    = 105;
  localparam logic [15:0] SYNC  = 16'h0C4A;
  localparam logic [15:0] OTHER = 16'h2000;
  localparam logic [15:0] FETCH = 16'h3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  lc_in = '0;
  logic [3:0]  dma = '0;
  logic [15:0] addr = '0;
  logic        strobe = 1'b0;
  logic        we = 1'b0;
  logic        halt, rdy;

  int vectors = 0;
  int fails   = 0;
  bit done_all = 1'b0;

  always #4 clk = ~clk;

  scanline_sync_stall i_scanline_sync_stall (
    .clk_i(clk), .rst_ni(rst_n), .line_cycle_i(lc_in), .dma_req_i(dma),
    .cpu_addr_i(addr), .cpu_strobe_i(strobe), .cpu_we_i(we),
    .halt_o(halt), .rdy_o(rdy)
  );

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Processor model: read SYNC, nw writes to waddr, then fetch reads.
  // A cycle completes when halt is low and either ready is high or it is a write.
  // exp1/exp2: cycles from start to completion of the first/second fetch read.
  task automatic run_seq(string tag, int start, int nw, logic [15:0] waddr,
                         int d_ref, int d_pf, int exp1, int exp2);
    int lc = start;
    int idx = 0;
    int nrd = 0;
    int off1 = -1;
    int off2 = -1;
    bit ok;
    for (int cyc = 0; cyc < 300 && nrd < 2; cyc++) begin
      @(negedge clk);
      lc_in  = 7'(lc);
      dma    = {1'b0, (lc == d_pf), 1'b0, (lc == d_ref)};
      strobe = 1'b1;
      if (idx == 0)       begin addr = SYNC;  we = 1'b0; end
      else if (idx <= nw) begin addr = waddr; we = 1'b1; end
      else                begin addr = FETCH; we = 1'b0; end
      #1;
      if (lc == d_ref || lc == d_pf) chk({tag, " R1 halt on dma"}, int'(halt), 1);
      if (lc == HB) chk({tag, " R7 ready at blank"}, int'(rdy), 1);
      ok = !halt && (rdy || we);
      if (ok) begin
        if (idx > nw) begin
          if (nrd == 0) off1 = cyc; else off2 = cyc;
          nrd++;
        end
        idx++;
      end
      lc = (lc + 1) % LINE;
    end
    @(negedge clk);
    strobe = 1'b0; we = 1'b0; dma = '0;
    if (nrd < 2) begin
      fails++;
      $display("FAIL %s processor hung actual=%0d expected=2 reads", tag, nrd);
    end
    chk({tag, " first read"},  off1, exp1);
    chk({tag, " second read"}, off2, exp2);
  endtask

  task automatic t_reset;
    @(negedge clk);
    dma = 4'b0001; #1;
    chk("R1 halt in reset", int'(halt), 1);
    chk("R10 ready in reset", int'(rdy), 1);
    dma = 4'b0000; #1;
    chk("R1 no halt idle", int'(halt), 0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R10 ready after reset", int'(rdy), 1);
  endtask

  // offsets from start (write at start+1); blank cycle 105
  task automatic t_single_free;  run_seq("R2 single free",       39, 1, SYNC,  -1, -1, 2, 66);  endtask
  task automatic t_single_ref;   run_seq("R2 grace lost refresh", 39, 1, SYNC,  41, -1, 66, 67); endtask
  task automatic t_rmw_free;     run_seq("R5 rmw free",          39, 2, SYNC,  -1, -1, 66, 67); endtask
  task automatic t_rmw_ref;      run_seq("R5 rmw refresh grace", 39, 2, SYNC,  41, -1, 66, 67); endtask
  task automatic t_triple;       run_seq("R6 repeat in wait",    39, 3, SYNC,  -1, -1, 66, 67); endtask
  task automatic t_halted_write; run_seq("R4 write halted",      39, 1, SYNC,  40, -1, 3, 66);  endtask
  task automatic t_blank_dma;    run_seq("R7 dma at blank",      39, 1, SYNC,  -1, 105, 2, 67); endtask
  task automatic t_fresh;        run_seq("R8 fresh wait",        106, 1, SYNC, -1, -1, 2, 113); endtask
  task automatic t_wrap;         run_seq("R8 wrap wait",         109, 1, SYNC, -1, -1, 2, 110); endtask
  task automatic t_other;        run_seq("R9 other address",     39, 1, OTHER, -1, -1, 2, 3);   endtask

  initial begin
    t_reset();
    t_single_free();
    t_single_ref();
    t_rmw_free();
    t_rmw_ref();
    t_triple();
    t_halted_write();
    t_blank_dma();
    t_fresh();
    t_wrap();
    t_other();
    if (!done_all) begin
      done_all = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done_all) begin
      done_all = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule